// File: doc/BRIEF.md
# Indexed Postbyte Address Generator

This block turns the single postbyte of an indexed-addressing instruction into a 16-bit effective address for a small 16-bit microcontroller core. It decodes the postbyte into one of six forms: a short signed constant, auto-increment or auto-decrement of an index register, a byte or word constant, an accumulator offset, and two indirect forms. When a form needs extension bytes it pulls one or two of them from the instruction-fetch port with a valid/ready handshake. The indirect forms issue one 16-bit memory read and use the returned word as the address.

The core pulses `start` with the postbyte while the block is idle. It holds the index registers and accumulators stable until `done`. When `done` is high for its single cycle, the block presents the address, an extra-cycle flag and a fault flag. In the auto-modify forms it also presents a write-back of the modified index register. With `restrict_en` high, the forms that carry extension bytes in the postbyte's constant or word-indirect encodings are refused: they complete at once with address zero and a fault. All arithmetic wraps modulo 2^16.

Top module: `idx_ea_gen`

## Requirements
- R1: With postbyte bit 5 clear, the address is base + sign-extended bits 4:0, where bit 4 is the sign. Base is selected by bits 7:6 (0 = X, 1 = Y, 2 = SP, 3 = PC). No byte is fetched, no memory read is made, no write-back occurs and the extra-cycle flag stays low.
- R2: With bit 5 set and bits 7:6 not 11, the register chosen by bits 7:6 is written back as register + step. If bit 3 is set, the step is bits 3:0 read as a negative 4-bit value (-8 to -1); otherwise it is bits 3:0 plus one (1 to 8). `wb_sel` uses the same 0..3 register code. With bit 4 clear (pre-modify), the address is the updated value.
- R3: In the auto-modify form with bit 4 set (post-modify), the address is the unmodified register value, while the write-back still carries register + step.
- R4: With bits 7:6 = 11, bit 2 = 0 and bit 1 = 0, one extension byte is fetched. It is extended to 16 bits with postbyte bit 0 as the sign and added to the base selected by bits 4:3. The extra-cycle flag is set.
- R5: With bits 7:6 = 11, bit 2 = 0, bits 1:0 = 10, two extension bytes are fetched, high byte first, and the 16-bit value is added to the base from bits 4:3. The extra-cycle flag is set.
- R6: With bits 7:6 = 11 and bits 2:0 = 011, two extension bytes (high first) are added to the base from bits 4:3. One 16-bit read is issued at that sum, and the returned word becomes the address. The extra-cycle flag is set.
- R7: With bits 7:6 = 11, bit 2 = 1 and bits 1:0 of 00, 01 or 10, the address is base (bits 4:3) + A, + B or + D. A and B are zero-extended. No byte is fetched and the extra-cycle flag stays low.
- R8: With bits 7:6 = 11 and bits 2:0 = 111, one 16-bit read is issued at base + D, and the returned word becomes the address. The extra-cycle flag is set.
- R9: While `restrict_en` is high at start, the forms of R4, R5 and R6 complete with address 0 and `fault` high. They fetch no byte, make no read and assert no write-back. All other forms behave as without restriction.
- R10: Every sum and every register update wraps modulo 2^16.
- R11: `done` is high for exactly one cycle per operation. `wb_en`, `fault` and `extra_cyc` are high only in that cycle.
- R12: After reset, `done`, `ext_req`, `mem_req` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation with `postbyte` (taken when idle) |
| postbyte | input | 8 | Indexed-mode postbyte |
| restrict_en | input | 1 | Refuse constant-offset and word-indirect forms |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter after all extension bytes |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| acc_d | input | 16 | Double accumulator D |
| ext_req | output | 1 | Block is ready for an extension byte |
| ext_valid | input | 1 | Fetch port presents a byte |
| ext_byte | input | 8 | Extension byte |
| mem_req | output | 1 | Indirect word read request |
| mem_addr | output | 16 | Indirect read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 16 | Word read from memory |
| wb_en | output | 1 | Index register write-back strobe |
| wb_sel | output | 2 | Register to write back (0 X, 1 Y, 2 SP, 3 PC) |
| wb_data | output | 16 | Value to write back |
| ea | output | 16 | Effective address |
| done | output | 1 | One-cycle completion pulse |
| extra_cyc | output | 1 | Form costs one extra cycle |
| fault | output | 1 | Form refused in restricted mode |

## Verification
The bench targets the sign boundaries. These are a 5-bit offset of all ones and a step code of 1000 (-8). A 9-bit offset with a zero byte but a negative sign bit checks that the sign comes from the postbyte and not the byte. A design that took the sign from the wrong bit would land 256 or 32 bytes away. Accumulator A and B with their top bit set expose sign-extending where zero-extending is required. A word offset that overflows 16 bits shows whether the sum wraps. Byte order is checked with distinct high and low extension bytes. Post-modify forms catch a design that returns the updated value. Restricted runs confirm that a refused form touches neither the fetch port nor memory, and that the accumulator-indirect and auto-modify forms still complete.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

   typedef enum logic [2:0] {
      MD_CONST5  = 3'd0,
      MD_AUTO    = 3'd1,
      MD_CONSTX  = 3'd2,
      MD_IND16   = 3'd3,
      MD_ACC     = 3'd4,
      MD_ACC_IND = 3'd5
   } ea_mode_e;

   typedef struct packed {
      ea_mode_e   mode;
      logic [1:0] base_sel;   // register code 0 X, 1 Y, 2 SP, 3 PC
      logic [1:0] ext_bytes;  // extension bytes to fetch
      logic       neg9;       // sign of the byte offset
      logic [1:0] acc_sel;    // accumulator choice
      logic       post;       // post-modify
      logic [3:0] stepcode;   // auto-modify step code
      logic [4:0] off5;       // short signed offset
      logic       long_form;  // refused under restriction
      logic       extra;      // costs an extra cycle
      logic       needs_mem;  // indirect read needed
   } pb_dec_t;

endpackage

// File: rtl/idx_pb_decode.sv
module idx_pb_decode
   import idx_ea_pkg::*;
(
   input  logic [7:0] pb,
   output pb_dec_t    dec
);

   always_comb begin
      dec          = '0;
      dec.mode     = MD_CONST5;
      dec.base_sel = pb[7:6];
      if (!pb[5]) begin
         dec.mode = MD_CONST5;
         dec.off5 = pb[4:0];
      end else if (pb[7:6] != 2'b11) begin
         dec.mode     = MD_AUTO;
         dec.stepcode = pb[3:0];
         dec.post     = pb[4];
      end else begin
         dec.base_sel = pb[4:3];
         if (pb[2:0] == 3'b011) begin
            dec.mode      = MD_IND16;
            dec.ext_bytes = 2'd2;
            dec.extra     = 1'b1;
            dec.needs_mem = 1'b1;
            dec.long_form = 1'b1;
         end else if (!pb[2]) begin
            dec.mode      = MD_CONSTX;
            dec.ext_bytes = pb[1] ? 2'd2 : 2'd1;
            dec.neg9      = pb[0];
            dec.extra     = 1'b1;
            dec.long_form = 1'b1;
         end else begin
            dec.acc_sel = pb[1:0];
            if (pb[1:0] == 2'b11) begin
               dec.mode      = MD_ACC_IND;
               dec.extra     = 1'b1;
               dec.needs_mem = 1'b1;
            end else begin
               dec.mode = MD_ACC;
            end
         end
      end
   end

endmodule

// File: rtl/idx_base_sel.sv
module idx_base_sel #(
   parameter int ADDR_W = 16,
   parameter int NREG   = 4,
   localparam int SEL_W = $clog2(NREG)
) (
   input  logic [NREG*ADDR_W-1:0] regs_flat,
   input  logic [SEL_W-1:0]       sel,
   output logic [ADDR_W-1:0]      base
);

   logic [ADDR_W-1:0] regs [NREG];

   generate
      if (NREG != (1 << SEL_W)) begin : g_bad_nreg
         $error("idx_base_sel: NREG must be a power of two");
      end
      for (genvar i = 0; i < NREG; i++) begin : g_split
         assign regs[i] = regs_flat[i*ADDR_W +: ADDR_W];
      end
   endgenerate

   assign base = regs[sel];

endmodule

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
   import idx_ea_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  ea_mode_e          mode,
   input  logic [4:0]        off5,
   input  logic [3:0]        stepcode,
   input  logic              post,
   input  logic              neg9,
   input  logic              wide,
   input  logic [1:0]        acc_sel,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] ext_word,
   input  logic [BYTE_W-1:0] acc_a,
   input  logic [BYTE_W-1:0] acc_b,
   input  logic [ADDR_W-1:0] acc_d,
   output logic [ADDR_W-1:0] sum,
   output logic [ADDR_W-1:0] direct_ea
);

   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] offset;

   always_comb begin
      if (stepcode[3])
         step = {{(ADDR_W-4){1'b1}}, stepcode};
      else
         step = {{(ADDR_W-4){1'b0}}, stepcode} + {{(ADDR_W-1){1'b0}}, 1'b1};
   end

   always_comb begin
      unique case (mode)
         MD_CONST5:  offset = {{(ADDR_W-5){off5[4]}}, off5};
         MD_AUTO:    offset = step;
         MD_CONSTX:  offset = wide ? ext_word
                                   : {{(ADDR_W-BYTE_W){neg9}}, ext_word[BYTE_W-1:0]};
         MD_IND16:   offset = ext_word;
         MD_ACC: begin
            case (acc_sel)
               2'd0:    offset = {{(ADDR_W-BYTE_W){1'b0}}, acc_a};
               2'd1:    offset = {{(ADDR_W-BYTE_W){1'b0}}, acc_b};
               default: offset = acc_d;
            endcase
         end
         MD_ACC_IND: offset = acc_d;
         default:    offset = '0;
      endcase
   end

   assign sum       = base + offset;
   assign direct_ea = (mode == MD_AUTO && post) ? base : sum;

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
   import idx_ea_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8,
   localparam int NREG  = 4,
   localparam int CNT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        postbyte,
   input  logic              restrict_en,
   input  logic [ADDR_W-1:0] reg_x,
   input  logic [ADDR_W-1:0] reg_y,
   input  logic [ADDR_W-1:0] reg_sp,
   input  logic [ADDR_W-1:0] reg_pc,
   input  logic [BYTE_W-1:0] acc_a,
   input  logic [BYTE_W-1:0] acc_b,
   input  logic [ADDR_W-1:0] acc_d,
   output logic              ext_req,
   input  logic              ext_valid,
   input  logic [BYTE_W-1:0] ext_byte,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              wb_en,
   output logic [1:0]        wb_sel,
   output logic [ADDR_W-1:0] wb_data,
   output logic [ADDR_W-1:0] ea,
   output logic              done,
   output logic              extra_cyc,
   output logic              fault
);

   generate
      if (ADDR_W != 2 * BYTE_W) begin : g_bad_width
         $error("idx_ea_gen: ADDR_W must be twice BYTE_W");
      end
   endgenerate

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_CALC, S_MEM, S_FIN
   } st_e;

   st_e               state;
   pb_dec_t           dec_in, dec_q;
   logic [ADDR_W-1:0] ext_q, addr_q, ea_q, wb_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              fault_q;
   logic [ADDR_W-1:0] base, sum, direct_ea;

   idx_pb_decode u_dec (
      .pb  (postbyte),
      .dec (dec_in)
   );

   idx_base_sel #(.ADDR_W(ADDR_W), .NREG(NREG)) u_base (
      .regs_flat ({reg_pc, reg_sp, reg_y, reg_x}),
      .sel       (dec_q.base_sel),
      .base      (base)
   );

   idx_addr_calc #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_calc (
      .mode      (dec_q.mode),
      .off5      (dec_q.off5),
      .stepcode  (dec_q.stepcode),
      .post      (dec_q.post),
      .neg9      (dec_q.neg9),
      .wide      (dec_q.ext_bytes[1]),
      .acc_sel   (dec_q.acc_sel),
      .base      (base),
      .ext_word  (ext_q),
      .acc_a     (acc_a),
      .acc_b     (acc_b),
      .acc_d     (acc_d),
      .sum       (sum),
      .direct_ea (direct_ea)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         dec_q   <= '0;
         ext_q   <= '0;
         addr_q  <= '0;
         ea_q    <= '0;
         wb_q    <= '0;
         cnt_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: begin
               if (start) begin
                  dec_q   <= dec_in;
                  ext_q   <= '0;
                  cnt_q   <= '0;
                  fault_q <= 1'b0;
                  if (restrict_en && dec_in.long_form) begin
                     fault_q <= 1'b1;
                     ea_q    <= '0;
                     state   <= S_FIN;
                  end else if (dec_in.ext_bytes != 2'd0) begin
                     state <= S_FETCH;
                  end else begin
                     state <= S_CALC;
                  end
               end
            end
            S_FETCH: begin
               if (ext_valid) begin
                  ext_q <= {ext_q[ADDR_W-BYTE_W-1:0], ext_byte};
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == dec_q.ext_bytes - 2'd1)
                     state <= S_CALC;
               end
            end
            S_CALC: begin
               wb_q <= sum;
               if (dec_q.needs_mem) begin
                  addr_q <= sum;
                  state  <= S_MEM;
               end else begin
                  ea_q  <= direct_ea;
                  state <= S_FIN;
               end
            end
            S_MEM: begin
               if (mem_ack) begin
                  ea_q  <= mem_rdata;
                  state <= S_FIN;
               end
            end
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign ext_req   = (state == S_FETCH);
   assign mem_req   = (state == S_MEM);
   assign mem_addr  = addr_q;
   assign done      = (state == S_FIN);
   assign ea        = ea_q;
   assign fault     = done && fault_q;
   assign extra_cyc = done && !fault_q && dec_q.extra;
   assign wb_en     = done && !fault_q && (dec_q.mode == MD_AUTO);
   assign wb_sel    = dec_q.base_sel;
   assign wb_data   = wb_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle");                  // R11
   AST_WB_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done) else $error("write-back outside done");                     // R11
   AST_FAULT_ZERO_EA: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (ea == '0 && !wb_en && !extra_cyc)) else $error("fault with effects"); // R9
   AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_req && mem_req)) else $error("fetch and read together");              // R6
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))) else $error("read dropped"); // R8
   AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && !ext_valid) |=> ext_req) else $error("fetch dropped");          // R5
   AST_FAULT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ext_req && !mem_req && !done && restrict_en && postbyte[7:5] == 3'b111 && !postbyte[2])
         |=> (done && fault)) else $error("refused form not faulted");             // R9

endmodule

// File: tb/idx_ea_gen_tb_top.sv
module idx_ea_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  postbyte = '0;
   logic        restrict_en = 1'b0;
   logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_sp = 16'h3FF0, reg_pc = 16'h8000;
   logic [7:0]  acc_a = 8'h80, acc_b = 8'hFF;
   logic [15:0] acc_d = 16'h1234;
   logic        ext_req, ext_valid = 1'b0;
   logic [7:0]  ext_byte = '0;
   logic        mem_req, mem_ack = 1'b0;
   logic [15:0] mem_addr, mem_rdata = '0;
   logic        wb_en, done, extra_cyc, fault;
   logic [1:0]  wb_sel;
   logic [15:0] wb_data, ea;

   int nvec = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   idx_ea_gen dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
      .restrict_en(restrict_en), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp),
      .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b), .acc_d(acc_d),
      .ext_req(ext_req), .ext_valid(ext_valid), .ext_byte(ext_byte),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data), .ea(ea), .done(done),
      .extra_cyc(extra_cyc), .fault(fault)
   );

   function automatic logic [15:0] memword(input logic [15:0] a);
      return a ^ 16'h5A5A;
   endfunction

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // One operation; checks every observable result against expectations.
   task automatic run_op(input string req, input logic [7:0] pb, input logic rs,
                         input logic [7:0] b0, input logic [7:0] b1,
                         input logic [15:0] exp_ea, input logic exp_extra,
                         input logic exp_fault, input int exp_nfetch, input int exp_nmem,
                         input logic [15:0] exp_maddr, input logic exp_wb,
                         input logic [1:0] exp_wsel, input logic [15:0] exp_wdata);
      logic [7:0]  fbuf [2];
      int          idx = 0, nfetch = 0, nmem = 0, ndone = 0, nwb = 0, cyc = 0;
      logic        pres = 1'b0, seen = 1'b0;
      logic [15:0] got_ea = '0, got_maddr = '0, got_wdata = '0;
      logic        got_extra = 1'b0, got_fault = 1'b0, got_wb = 1'b0;
      logic [1:0]  got_wsel = '0;
      fbuf[0] = b0; fbuf[1] = b1;
      @(negedge clk);
      postbyte = pb; restrict_en = rs; start = 1'b1;
      forever begin
         @(negedge clk);
         start = 1'b0;
         cyc++;
         if (pres) begin idx++; nfetch++; end
         if (wb_en) nwb++;
         if (seen) begin
            if (done) ndone++;
            break;
         end
         if (done) begin
            seen = 1'b1; ndone++;
            got_ea = ea; got_extra = extra_cyc; got_fault = fault;
            got_wb = wb_en; got_wsel = wb_sel; got_wdata = wb_data;
         end
         pres      = ext_req && idx < 2;
         ext_valid = pres;
         ext_byte  = fbuf[idx < 2 ? idx : 1];
         mem_ack   = mem_req;
         if (mem_req) begin
            nmem++; got_maddr = mem_addr; mem_rdata = memword(mem_addr);
         end
         if (cyc > 100) begin
            nfail++;
            $display("FAIL %s watchdog: actual no done expected done", req);
            break;
         end
      end
      ext_valid = 1'b0; mem_ack = 1'b0;
      chk(got_ea, exp_ea, {req, " ea"});
      chk(16'(got_extra), 16'(exp_extra), {req, " extra_cyc"});
      chk(16'(got_fault), 16'(exp_fault), {req, " fault"});
      chk(16'(nfetch), 16'(exp_nfetch), {req, " fetched bytes"});
      chk(16'(nmem), 16'(exp_nmem), {req, " memory reads"});
      if (exp_nmem != 0) chk(got_maddr, exp_maddr, {req, " read address"});
      chk(16'(got_wb), 16'(exp_wb), {req, " wb_en"});
      chk(16'(nwb), 16'(exp_wb), {req, " wb_en cycles (R11)"});
      if (exp_wb) begin
         chk(16'(got_wsel), 16'(exp_wsel), {req, " wb_sel"});
         chk(got_wdata, exp_wdata, {req, " wb_data"});
      end
      chk(16'(ndone), 16'd1, {req, " done width (R11)"});
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(16'(done), 16'd0, "R12 done after reset");
      chk(16'(ext_req), 16'd0, "R12 ext_req after reset");
      chk(16'(mem_req), 16'd0, "R12 mem_req after reset");
      chk(16'(wb_en), 16'd0, "R12 wb_en after reset");
   endtask

   task automatic t_const5;
      run_op("R1 Y-1",   8'h5F, 0, 0, 0, 16'h1FFF, 0, 0, 0, 0, 0, 0, 0, 0);
      run_op("R1 X+15",  8'h0F, 0, 0, 0, 16'h100F, 0, 0, 0, 0, 0, 0, 0, 0);
      run_op("R1 PC-16", 8'hD0, 0, 0, 0, 16'h7FF0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_auto;
      run_op("R2 pre X+4",  8'h23, 0, 0, 0, 16'h1004, 0, 0, 0, 0, 0, 1, 2'd0, 16'h1004);
      run_op("R2 pre Y-8",  8'h68, 0, 0, 0, 16'h1FF8, 0, 0, 0, 0, 0, 1, 2'd1, 16'h1FF8);
      run_op("R3 post SP-1", 8'hBF, 0, 0, 0, 16'h3FF0, 0, 0, 0, 0, 0, 1, 2'd2, 16'h3FEF);
      run_op("R3 post X+8", 8'h37, 0, 0, 0, 16'h1000, 0, 0, 0, 0, 0, 1, 2'd0, 16'h1008);
   endtask

   task automatic t_constx;
      run_op("R4 X+10h",     8'hE0, 0, 8'h10, 0, 16'h1010, 1, 0, 1, 0, 0, 0, 0, 0);
      run_op("R4 X neg byte", 8'hE1, 0, 8'h00, 0, 16'h0F00, 1, 0, 1, 0, 0, 0, 0, 0);
      run_op("R5 Y+1234h",   8'hEA, 0, 8'h12, 8'h34, 16'h3234, 1, 0, 2, 0, 0, 0, 0, 0);
      run_op("R10 SP wrap",  8'hF2, 0, 8'hF0, 8'h20, 16'h3010, 1, 0, 2, 0, 0, 0, 0, 0);
   endtask

   task automatic t_indirect;
      run_op("R6 [8,X]", 8'hE3, 0, 8'h00, 8'h08, memword(16'h1008), 1, 0, 2, 1, 16'h1008, 0, 0, 0);
      run_op("R8 [D,X]", 8'hE7, 0, 0, 0, memword(16'h2234), 1, 0, 0, 1, 16'h2234, 0, 0, 0);
   endtask

   task automatic t_acc;
      run_op("R7 A,X", 8'hE4, 0, 0, 0, 16'h1080, 0, 0, 0, 0, 0, 0, 0, 0);
      run_op("R7 B,Y", 8'hED, 0, 0, 0, 16'h20FF, 0, 0, 0, 0, 0, 0, 0, 0);
      run_op("R7 D,X", 8'hE6, 0, 0, 0, 16'h2234, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_restricted;
      run_op("R9 byte refused", 8'hE0, 1, 8'h10, 0, 16'h0000, 0, 1, 0, 0, 0, 0, 0, 0);
      run_op("R9 word refused", 8'hEA, 1, 8'h12, 8'h34, 16'h0000, 0, 1, 0, 0, 0, 0, 0, 0);
      run_op("R9 ind refused",  8'hE3, 1, 8'h00, 8'h08, 16'h0000, 0, 1, 0, 0, 0, 0, 0, 0);
      run_op("R9 D-ind allowed", 8'hE7, 1, 0, 0, memword(16'h2234), 1, 0, 0, 1, 16'h2234, 0, 0, 0);
      run_op("R9 auto allowed", 8'h23, 1, 0, 0, 16'h1004, 0, 0, 0, 0, 0, 1, 2'd0, 16'h1004);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_const5();
      t_auto();
      t_constx();
      t_indirect();
      t_acc();
      t_restricted();
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule